// File: doc/BRIEF.md
# Panel Reset and Refresh Sequencer

This block drives a monochrome electrophoretic panel controller through a byte-wide command/data master. It performs four operations on request: a hardware reset followed by the register initialisation stream, a full or partial refresh, the set-up and loading of a partial window from pixel coordinates, and entry into deep sleep. For every byte it raises a request with a command/data flag. It holds that request until the master accepts it. Waveform tables and pixel data are not stored in the block. When the sequencer reaches a position where such bytes belong, it marks each request as streamed, and the master takes the byte from an external source.

Whenever the sequence has to wait on the panel, the sequencer polls the active-low busy line. A millisecond time base, derived from a clock-cycles-per-millisecond parameter, times both the reset pulse and the busy timeout. An operation that finishes returns a one-cycle done pulse. A busy line that never clears returns a timeout pulse instead. After deep sleep, or while an operation is running, every request except reset is refused with a reject pulse.

Top module: `epd_seq`

## Requirements
- R1: The reset operation drives `panel_rst_n` low for at least `RST_LOW_MS` milliseconds (`CYC_PER_MS` cycles each). It then raises the line and waits at least `RST_SETTLE_MS` milliseconds before any byte request. No byte request occurs while `panel_rst_n` is low.
- R2: After the reset pulse, the initialisation stream is sent in this order: command 0x00 with data 0x3F 0x0A; command 0x61 with data 0x03 0x18 0x02 0x58, followed by a busy wait; command 0x65 with four 0x00; command 0x03 with 0x20; command 0x01 with 0x07 0x17 0x3F 0x3F 0x17; command 0x82 with 0x24; command 0x06 with 0x25 0x25 0x3C 0x37; command 0x30 with 0x09; command 0xE1 with 0x02. `tx_dc` is 0 for a command byte and 1 for a data byte.
- R3: `busy_n` low means busy. A busy wait continues only once `busy_n` reads high. If the line stays low for `BUSY_TIMEOUT_MS` milliseconds, the operation ends with a one-cycle `timeout_err` pulse and no `done`.
- R4: A refresh (op code 1) sends command 0x50, then data 0xA9 when `op_full` is 1 or 0x29 when it is 0, then data 0x07. It then sends commands 0x20 to 0x24 in order, each followed by 42 streamed data bytes (`tx_stream`=1). It ends with command 0x04 and a busy wait, then command 0x12 and a busy wait.
- R5: A window operation (op code 2) sends command 0x91, then command 0x90 with nine data bytes: (x0 AND 0xFFF8), (x1 OR 0x0007), y0 and y1, each as high byte then low byte, and finally 0x01. It then sends command 0x13 followed by N streamed bytes, where N = ((x1 OR 7)/8 − x0/8 + 1) × (y1 − y0 + 1), and ends with command 0x92.
- R6: Deep sleep (op code 3) sends command 0x07 with data 0xA5. From then on, op codes 1, 2 and 3 are refused with a `reject_err` pulse and cause no byte request, until a reset operation (op code 0) has been accepted.
- R7: A request with op code 1, 2 or 3 made while an operation runs is refused with `reject_err`. The running operation continues with its byte stream unchanged.
- R8: `done` pulses for one cycle after the last step of each operation that completes.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_byte` and `tx_dc` hold their values.
- R10: After synchronous reset, `panel_rst_n` is 1 and `tx_valid`, `done`, `timeout_err` and `reject_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 2 | 0 reset+init, 1 refresh, 2 window, 3 deep sleep |
| op_full | input | 1 | Refresh type: 1 full, 0 partial |
| win_x0 | input | 16 | Window start column |
| win_x1 | input | 16 | Window end column |
| win_y0 | input | 16 | Window start row |
| win_y1 | input | 16 | Window end row |
| busy_n | input | 1 | Panel busy, active low |
| panel_rst_n | output | 1 | Panel reset, active low |
| tx_valid | output | 1 | Byte request to the master |
| tx_dc | output | 1 | 0 command byte, 1 data byte |
| tx_stream | output | 1 | Byte comes from the external source |
| tx_byte | output | 8 | Byte value when not streamed |
| tx_ready | input | 1 | Master accepts the byte |
| done | output | 1 | Operation completed |
| timeout_err | output | 1 | Busy wait timed out |
| reject_err | output | 1 | Request refused |

## Verification
The embedded properties watch, on every cycle, the parts of the behaviour that are local in time. They check that a stalled request holds its byte and flag, that no byte is requested while the panel is held in reset, that a sleeping idle block stays silent, that a reject follows a request, and that the millisecond prescaler stays in range. Other behaviour can only be shown by the bench's scenarios, because it depends on whole operations. This covers the exact byte order of the initialisation, refresh and window streams, the snapped window coordinates and the streamed byte count, the length of the reset pulse and the settling gap, the waits that follow each busy-raising command, the timeout path, and recovery from deep sleep through a reset.

// File: rtl/epd_seq_pkg.sv
// Package for the panel sequencer: operation codes, step kinds and the
// reset/initialisation script. Assumes 16-bit panel coordinates.
package epd_seq_pkg;

    typedef enum logic [1:0] {
        OP_INIT    = 2'd0,
        OP_REFRESH = 2'd1,
        OP_WINDOW  = 2'd2,
        OP_SLEEP   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        K_CMD    = 3'd0,
        K_DATA   = 3'd1,
        K_STREAM = 3'd2,
        K_BUSY   = 3'd3,
        K_RSTLO  = 3'd4,
        K_SETTLE = 3'd5,
        K_END    = 3'd6
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] val;
    } step_t;

    localparam int COORD_W     = 16;
    localparam int TABLE_LEN   = 42;
    localparam int TABLE_COUNT = 5;
    localparam int INIT_STEPS  = 37;

    // {kind, value}: 0xx command, 1xx data, 300 busy, 400 reset low, 500 settle, 600 end
    localparam logic [10:0] INIT_TAB [INIT_STEPS] = '{
        11'h400, 11'h500, 11'h300,
        11'h000, 11'h13F, 11'h10A,
        11'h061, 11'h103, 11'h118, 11'h102, 11'h158, 11'h300,
        11'h065, 11'h100, 11'h100, 11'h100, 11'h100,
        11'h003, 11'h120,
        11'h001, 11'h107, 11'h117, 11'h13F, 11'h13F, 11'h117,
        11'h082, 11'h124,
        11'h006, 11'h125, 11'h125, 11'h13C, 11'h137,
        11'h030, 11'h109,
        11'h0E1, 11'h102,
        11'h600
    };

    function automatic step_t mk(kind_e k, logic [7:0] v);
        step_t s;
        s.kind = k;
        s.val  = v;
        return s;
    endfunction

endpackage

// File: rtl/epd_ms_timer.sv
// Millisecond time base: counts whole milliseconds since the last clear.
// Assumes CYC_PER_MS >= 1; the count saturates at its maximum.
module epd_ms_timer #(
    parameter int CYC_PER_MS = 125000,
    parameter int MS_W       = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    output logic [MS_W-1:0] ms
);
    localparam int PRE_W = $clog2(CYC_PER_MS + 1);

    logic [PRE_W-1:0] pre_q;

    // prescale the clock into millisecond ticks and count them
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q <= '0;
            ms    <= '0;
        end else if (pre_q == PRE_W'(CYC_PER_MS - 1)) begin
            pre_q <= '0;
            if (ms != '1) ms <= ms + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assert_pre_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q < PRE_W'(CYC_PER_MS));

endmodule

// File: rtl/epd_script.sv
// Step generator: maps (operation, step index) onto one step of the
// byte/wait script. Purely combinational; assumes the coordinates are stable
// while an operation runs.
module epd_script
    import epd_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  op_e                op,
    input  logic               full,
    input  logic [IDX_W-1:0]   idx,
    input  logic [COORD_W-1:0] x0,
    input  logic [COORD_W-1:0] x1,
    input  logic [COORD_W-1:0] y0,
    input  logic [COORD_W-1:0] y1,
    output step_t              step
);
    localparam int RF_TAIL = 3 + 2 * TABLE_COUNT;

    logic [3:0][COORD_W-1:0] coord;
    logic [8:0][7:0]         win;

    assign coord[0] = x0 & 16'hFFF8;
    assign coord[1] = x1 | 16'h0007;
    assign coord[2] = y0;
    assign coord[3] = y1;

    generate
        for (genvar g = 0; g < 4; g++) begin : g_win
            assign win[2*g]   = coord[g][15:8];
            assign win[2*g+1] = coord[g][7:0];
        end
    endgenerate
    assign win[8] = 8'h01;

    // select the step for the current operation and position
    always_comb begin
        int r;
        r    = int'(idx);
        step = mk(K_END, 8'h00);
        case (op)
            OP_INIT: begin
                if (r < INIT_STEPS) step = step_t'(INIT_TAB[r]);
            end
            OP_REFRESH: begin
                if (r == 0)            step = mk(K_CMD, 8'h50);
                else if (r == 1)       step = mk(K_DATA, full ? 8'hA9 : 8'h29);
                else if (r == 2)       step = mk(K_DATA, 8'h07);
                else if (r < RF_TAIL)  step = ((r - 3) % 2 == 0)
                                              ? mk(K_CMD, 8'h20 + 8'((r - 3) / 2))
                                              : mk(K_STREAM, 8'h00);
                else if (r == RF_TAIL)     step = mk(K_CMD, 8'h04);
                else if (r == RF_TAIL + 1) step = mk(K_BUSY, 8'h00);
                else if (r == RF_TAIL + 2) step = mk(K_CMD, 8'h12);
                else if (r == RF_TAIL + 3) step = mk(K_BUSY, 8'h00);
            end
            OP_WINDOW: begin
                if (r == 0)       step = mk(K_CMD, 8'h91);
                else if (r == 1)  step = mk(K_CMD, 8'h90);
                else if (r < 11)  step = mk(K_DATA, win[r-2]);
                else if (r == 11) step = mk(K_CMD, 8'h13);
                else if (r == 12) step = mk(K_STREAM, 8'h00);
                else if (r == 13) step = mk(K_CMD, 8'h92);
            end
            default: begin
                if (r == 0)      step = mk(K_CMD, 8'h07);
                else if (r == 1) step = mk(K_DATA, 8'hA5);
            end
        endcase
    end

endmodule

// File: rtl/epd_seq.sv
// Panel reset and refresh sequencer (top). Walks the script one step at a
// time, hands bytes to a command/data master with a valid/ready handshake,
// polls the active-low busy line with a timeout and tracks deep sleep.
// Assumes win_x1 >= win_x0 and win_y1 >= win_y0 for window operations.
module epd_seq
    import epd_seq_pkg::*;
#(
    parameter int CYC_PER_MS      = 125000,
    parameter int RST_LOW_MS      = 15,
    parameter int RST_SETTLE_MS   = 10,
    parameter int BUSY_TIMEOUT_MS = 5000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [1:0]         op_code,
    input  logic               op_full,
    input  logic [COORD_W-1:0] win_x0,
    input  logic [COORD_W-1:0] win_x1,
    input  logic [COORD_W-1:0] win_y0,
    input  logic [COORD_W-1:0] win_y1,
    input  logic               busy_n,
    output logic               panel_rst_n,
    output logic               tx_valid,
    output logic               tx_dc,
    output logic               tx_stream,
    output logic [7:0]         tx_byte,
    input  logic               tx_ready,
    output logic               done,
    output logic               timeout_err,
    output logic               reject_err
);
    localparam int MAX_MS = (BUSY_TIMEOUT_MS > RST_LOW_MS) ? BUSY_TIMEOUT_MS : RST_LOW_MS;
    localparam int MS_W   = $clog2(MAX_MS + 1) + 1;
    localparam int IDX_W  = 6;
    localparam int CNT_W  = 2 * COORD_W;

    logic               run_q, asleep_q, full_q;
    op_e                op_q;
    logic [IDX_W-1:0]   idx_q;
    logic [CNT_W-1:0]   sent_q;
    logic [COORD_W-1:0] x0_q, x1_q, y0_q, y1_q;
    logic [MS_W-1:0]    ms;
    step_t              step;

    logic accept_init, accept_other, reject, hs, advance, expired, tmr_clear;
    logic [COORD_W-1:0] cols, rows;
    logic [CNT_W-1:0]   stream_len;

    epd_script #(.IDX_W(IDX_W)) u_script (
        .op(op_q), .full(full_q), .idx(idx_q),
        .x0(x0_q), .x1(x1_q), .y0(y0_q), .y1(y1_q), .step(step)
    );

    epd_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .ms(ms)
    );

    // request classification: reset always wins, others need an idle awake block
    always_comb begin
        accept_init  = op_valid && (op_code == 2'd0);
        accept_other = op_valid && (op_code != 2'd0) && !run_q && !asleep_q;
        reject       = op_valid && (op_code != 2'd0) && (run_q || asleep_q);
    end

    // byte interface driven straight from the current step
    always_comb begin
        tx_valid    = run_q && (step.kind inside {K_CMD, K_DATA, K_STREAM});
        tx_dc       = (step.kind != K_CMD);
        tx_stream   = (step.kind == K_STREAM);
        tx_byte     = step.val;
        panel_rst_n = !(run_q && step.kind == K_RSTLO);
        hs          = tx_valid && tx_ready;
    end

    // length of the streamed run: one table, or the snapped window area
    always_comb begin
        cols       = ((x1_q | 16'h0007) >> 3) - (x0_q >> 3) + 16'd1;
        rows       = y1_q - y0_q + 16'd1;
        stream_len = (op_q == OP_REFRESH) ? CNT_W'(TABLE_LEN)
                                          : CNT_W'(cols) * CNT_W'(rows);
    end

    // decide whether the current step is finished or has timed out
    always_comb begin
        case (step.kind)
            K_CMD, K_DATA: advance = hs;
            K_STREAM:      advance = hs && (sent_q == stream_len - 1'b1);
            K_BUSY:        advance = busy_n;
            K_RSTLO:       advance = (ms >= MS_W'(RST_LOW_MS));
            K_SETTLE:      advance = (ms >= MS_W'(RST_SETTLE_MS));
            default:       advance = 1'b1;
        endcase
        expired   = run_q && (step.kind == K_BUSY) && !busy_n
                    && (ms >= MS_W'(BUSY_TIMEOUT_MS));
        tmr_clear = accept_init || accept_other || (run_q && advance);
    end

    // sequencer state: operation latch, step pointer, stream count, status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            asleep_q    <= 1'b0;
            full_q      <= 1'b0;
            op_q        <= OP_INIT;
            idx_q       <= '0;
            sent_q      <= '0;
            x0_q        <= '0;
            x1_q        <= '0;
            y0_q        <= '0;
            y1_q        <= '0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            reject_err  <= 1'b0;
        end else begin
            done        <= 1'b0;
            timeout_err <= 1'b0;
            reject_err  <= reject;
            if (accept_init || accept_other) begin
                run_q  <= 1'b1;
                op_q   <= op_e'(op_code);
                full_q <= op_full;
                idx_q  <= '0;
                sent_q <= '0;
                x0_q   <= win_x0;
                x1_q   <= win_x1;
                y0_q   <= win_y0;
                y1_q   <= win_y1;
                if (accept_init) asleep_q <= 1'b0;
            end else if (run_q) begin
                if (expired) begin
                    run_q       <= 1'b0;
                    timeout_err <= 1'b1;
                end else if (advance) begin
                    sent_q <= '0;
                    if (step.kind == K_END) begin
                        run_q <= 1'b0;
                        done  <= 1'b1;
                        if (op_q == OP_SLEEP) asleep_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end else if (hs) begin
                    sent_q <= sent_q + 1'b1;
                end
            end
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !op_valid) |=> (tx_valid && $stable(tx_byte) && $stable(tx_dc)));

    assert_quiet_rst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> !tx_valid);

    assert_sleep_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && !run_q) |-> (!tx_valid && panel_rst_n));

    assert_reject_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reject_err |-> $past(op_valid));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!run_q && !timeout_err));

endmodule

// File: tb/epd_seq_test.sv
// Bench for the panel sequencer: a window vector table walked by one loop,
// then directed tests for reset, init, timeout, refresh, reject and sleep.
module epd_seq_test;
    localparam int LOG_MAX  = 1024;
    localparam int BUSY_CYC = 12;

    // window vectors: {x0, x1, y0, y1, expected streamed byte count}
    localparam logic [79:0] WIN_VEC [4] = '{
        {16'd3,   16'd20,  16'd5,   16'd6,   16'd6},
        {16'd8,   16'd15,  16'd0,   16'd0,   16'd1},
        {16'd261, 16'd281, 16'd256, 16'd259, 16'd16},
        {16'd785, 16'd791, 16'd527, 16'd527, 16'd1}
    };

    // expected init bytes: {dc, byte}
    localparam logic [8:0] INIT_EXP [32] = '{
        9'h000, 9'h13F, 9'h10A,
        9'h061, 9'h103, 9'h118, 9'h102, 9'h158,
        9'h065, 9'h100, 9'h100, 9'h100, 9'h100,
        9'h003, 9'h120,
        9'h001, 9'h107, 9'h117, 9'h13F, 9'h13F, 9'h117,
        9'h082, 9'h124,
        9'h006, 9'h125, 9'h125, 9'h13C, 9'h137,
        9'h030, 9'h109,
        9'h0E1, 9'h102
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [1:0] op_code = 2'd0;
    logic op_full = 1'b0;
    logic [15:0] win_x0 = '0, win_x1 = '0, win_y0 = '0, win_y1 = '0;
    logic busy_n, panel_rst_n, tx_valid, tx_dc, tx_stream, tx_ready;
    logic [7:0] tx_byte;
    logic done, timeout_err, reject_err;

    logic stuck = 1'b0;
    logic stall = 1'b0;
    int   busy_hold = 0;
    int   log_n = 0;
    int   cyc = 0;
    int   t_fall = 0, t_rise = 0, t_first = 0;
    logic seen_tx = 1'b1, prev_prst = 1'b1, sent_busy = 1'b0;
    logic [7:0] lg_byte [LOG_MAX];
    logic       lg_dc   [LOG_MAX];
    logic       lg_str  [LOG_MAX];

    int errors = 0, checks = 0;
    int base;
    logic got_done, got_to, rej_seen;

    always #4 clk = ~clk;

    epd_seq #(.CYC_PER_MS(4), .RST_LOW_MS(15), .RST_SETTLE_MS(10), .BUSY_TIMEOUT_MS(20)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_full(op_full),
        .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0), .win_y1(win_y1),
        .busy_n(busy_n), .panel_rst_n(panel_rst_n), .tx_valid(tx_valid), .tx_dc(tx_dc),
        .tx_stream(tx_stream), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .done(done), .timeout_err(timeout_err), .reject_err(reject_err)
    );

    // panel and master model: logs accepted bytes, raises busy after 0x04/0x12
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            busy_hold <= 0;
            busy_n    <= 1'b1;
            tx_ready  <= 1'b1;
        end else begin
            prev_prst <= panel_rst_n;
            if (prev_prst && !panel_rst_n) t_fall <= cyc;
            if (!prev_prst && panel_rst_n) begin t_rise <= cyc; seen_tx <= 1'b0; end
            if (tx_valid && !seen_tx) begin t_first <= cyc; seen_tx <= 1'b1; end
            if (tx_valid && tx_ready) begin
                if (log_n < LOG_MAX) begin
                    lg_byte[log_n] <= tx_byte;
                    lg_dc[log_n]   <= tx_dc;
                    lg_str[log_n]  <= tx_stream;
                end
                log_n <= log_n + 1;
                if (!busy_n) sent_busy <= 1'b1;
            end
            if (tx_valid && tx_ready && !tx_dc && (tx_byte == 8'h04 || tx_byte == 8'h12)) begin
                busy_hold <= BUSY_CYC;
                busy_n    <= 1'b0;
            end else if (busy_hold > 0) begin
                busy_hold <= busy_hold - 1;
                busy_n    <= 1'b0;
            end else begin
                busy_n <= !stuck;
            end
            tx_ready <= stall ? !tx_ready : 1'b1;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_op(input logic [1:0] c, input logic f,
                            input logic [15:0] a, input logic [15:0] b,
                            input logic [15:0] p, input logic [15:0] q);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_full = f;
        win_x0 = a; win_x1 = b; win_y0 = p; win_y1 = q;
        @(negedge clk);
        op_valid = 1'b0;
        rej_seen = reject_err;
    endtask

    task automatic wait_end(input int limit);
        got_done = 1'b0; got_to = 1'b0;
        for (int i = 0; i < limit; i++) begin
            if (done) begin got_done = 1'b1; break; end
            if (timeout_err) begin got_to = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic check_refresh(input logic full, input string tag);
        int nstr;
        logic [7:0] mode;
        mode = full ? 8'hA9 : 8'h29;
        check(got_done, tag, got_done, 1);
        check(log_n - base == 220, tag, log_n - base, 220);
        check(lg_byte[base] == 8'h50 && !lg_dc[base], tag, lg_byte[base], 8'h50);
        check(lg_byte[base+1] == mode && lg_dc[base+1], tag, lg_byte[base+1], mode);
        check(lg_byte[base+2] == 8'h07, tag, lg_byte[base+2], 8'h07);
        for (int t = 0; t < 5; t++) begin
            nstr = 0;
            for (int k = 1; k <= 42; k++) if (lg_str[base+3+43*t+k] && lg_dc[base+3+43*t+k]) nstr++;
            check(lg_byte[base+3+43*t] == 8'h20 + 8'(t) && !lg_dc[base+3+43*t],
                  tag, lg_byte[base+3+43*t], 32 + t);
            check(nstr == 42, tag, nstr, 42);
        end
        check(lg_byte[base+218] == 8'h04 && !lg_dc[base+218], tag, lg_byte[base+218], 4);
        check(lg_byte[base+219] == 8'h12 && !lg_dc[base+219], tag, lg_byte[base+219], 18);
    endtask

    initial begin
        logic [15:0] xs, xe, ys, ye, n;
        logic [7:0]  wexp [9];
        int          dt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(panel_rst_n && !tx_valid && !done && !timeout_err && !reject_err, "R10",
              {panel_rst_n, tx_valid, done, timeout_err, reject_err}, 5'b10000);

        // R1/R2: reset pulse and init stream
        base = log_n;
        start_op(2'd0, 1'b0, 0, 0, 0, 0);
        wait_end(2000);
        check(got_done, "R8", got_done, 1);
        dt = t_rise - t_fall;
        check(dt >= 60 && dt <= 62, "R1 pulse", dt, 60);
        dt = t_first - t_rise;
        check(dt >= 40, "R1 settle", dt, 40);
        check(log_n - base == 32, "R2 count", log_n - base, 32);
        for (int i = 0; i < 32; i++)
            check({lg_dc[base+i], lg_byte[base+i]} == INIT_EXP[i], "R2",
                  {lg_dc[base+i], lg_byte[base+i]}, INIT_EXP[i]);

        // R3: busy never clears
        stuck = 1'b1;
        base = log_n;
        start_op(2'd0, 1'b0, 0, 0, 0, 0);
        wait_end(2000);
        check(got_to && !got_done, "R3 timeout", {got_to, got_done}, 2'b10);
        check(log_n == base, "R3 no bytes", log_n - base, 0);
        stuck = 1'b0;
        start_op(2'd0, 1'b0, 0, 0, 0, 0);
        wait_end(2000);
        check(got_done, "R3 recover", got_done, 1);

        // R4: full and partial refresh, with busy waits honoured
        sent_busy = 1'b0;
        base = log_n;
        start_op(2'd1, 1'b1, 0, 0, 0, 0);
        wait_end(3000);
        check_refresh(1'b1, "R4 full");
        check(!sent_busy, "R3 wait", sent_busy, 0);
        base = log_n;
        start_op(2'd1, 1'b0, 0, 0, 0, 0);
        wait_end(3000);
        check_refresh(1'b0, "R4 partial");

        // R5 vector loop (R9: odd vectors with a stalling master)
        for (int v = 0; v < 4; v++) begin
            {xs, xe, ys, ye, n} = WIN_VEC[v];
            stall = v[0];
            wexp = '{ 8'(((xs & 16'hFFF8) >> 8)), 8'(xs & 16'hFFF8),
                      8'(((xe | 16'h0007) >> 8)), 8'(xe | 16'h0007),
                      ys[15:8], ys[7:0], ye[15:8], ye[7:0], 8'h01 };
            base = log_n;
            start_op(2'd2, 1'b0, xs, xe, ys, ye);
            wait_end(3000);
            check(got_done, "R5 done", got_done, 1);
            check(log_n - base == 13 + int'(n), v[0] ? "R9 count" : "R5 count", log_n - base, 13 + int'(n));
            check(lg_byte[base] == 8'h91 && lg_byte[base+1] == 8'h90 && !lg_dc[base+1], "R5 head",
                  lg_byte[base+1], 8'h90);
            for (int k = 0; k < 9; k++)
                check(lg_byte[base+2+k] == wexp[k] && lg_dc[base+2+k], v[0] ? "R9 byte" : "R5 byte",
                      lg_byte[base+2+k], wexp[k]);
            check(lg_byte[base+11] == 8'h13 && lg_str[base+12] && lg_str[base+11+int'(n)],
                  "R5 stream", lg_byte[base+11], 8'h13);
            check(lg_byte[base+12+int'(n)] == 8'h92 && !lg_str[base+12+int'(n)], "R5 tail",
                  lg_byte[base+12+int'(n)], 8'h92);
        end
        stall = 1'b0;

        // R7: request during a running refresh is refused
        base = log_n;
        start_op(2'd1, 1'b1, 0, 0, 0, 0);
        repeat (5) @(negedge clk);
        start_op(2'd2, 1'b0, 0, 7, 0, 0);
        check(rej_seen, "R7 reject", rej_seen, 1);
        wait_end(3000);
        check(got_done && log_n - base == 220, "R7 intact", log_n - base, 220);

        // R6: deep sleep, refusal, wake by reset
        base = log_n;
        start_op(2'd3, 1'b0, 0, 0, 0, 0);
        wait_end(100);
        check(got_done && log_n - base == 2, "R6 count", log_n - base, 2);
        check(lg_byte[base] == 8'h07 && !lg_dc[base] && lg_byte[base+1] == 8'hA5 && lg_dc[base+1],
              "R6 bytes", lg_byte[base+1], 8'hA5);
        base = log_n;
        start_op(2'd1, 1'b1, 0, 0, 0, 0);
        check(rej_seen, "R6 reject", rej_seen, 1);
        wait_end(50);
        check(!got_done && log_n == base, "R6 silent", log_n - base, 0);
        start_op(2'd0, 1'b0, 0, 0, 0, 0);
        wait_end(2000);
        check(got_done && log_n - base == 32, "R6 wake", log_n - base, 32);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule